// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Steer

This block sits between an in-order fetch buffer and two issue pipes that are not interchangeable. The arithmetic pipe takes only fixed- or floating-point math. The general pipe takes everything else: logic, loads, stores and branches. Each cycle the buffer presents its two oldest entries. The block sorts each entry into one of the two classes and routes it to the pipe that can run it. It then tells the buffer how many entries to pop.

Two entries of the same class cannot start together, so such a pair is split across two cycles. In that case the older entry issues now. The younger one stays at the head of the buffer and goes out next cycle. Program order always holds: the younger entry never goes out while the older one is waiting on a busy pipe. The decision is purely combinational, so the pop count returns to the buffer in the same cycle in which the entries are presented.

Top module: `pair_steer`

## Requirements
- R1: An opcode belongs to the arithmetic class when `(op & ARITH_MASK) == ARITH_MATCH`. With the default 8-bit opcode, this means bits [7:6] equal 2'b01. Any other value in bits [7:6] (00, 10 or 11) is a general-class opcode.
- R2: `alu_vld` is only ever high with an arithmetic-class opcode on `alu_op`.
- R3: `aux_vld` is only ever high with a general-class opcode on `aux_op`.
- R4: When both slots are valid, hold opcodes of different classes, and both pipes are ready, both entries issue in the same cycle and `pop_cnt` is 2.
- R5: When both slots are valid and hold opcodes of the same class, only the older entry (slot 0) issues, provided its pipe is ready. `pop_cnt` is then 1.
- R6: When the pipe needed by the oldest valid entry has its ready input low, nothing issues and `pop_cnt` is 0, whatever the younger entry holds.
- R7: When the older entry can issue but the younger entry's pipe is not ready, only the older entry issues and `pop_cnt` is 1.
- R8: An invalid slot is empty. With no valid slot, nothing issues and `pop_cnt` is 0. With exactly one valid slot (either slot 0 or slot 1), that entry issues to its own pipe if that pipe is ready, and `pop_cnt` is 1.
- R9: `pop_cnt` always equals the number of pipe valid outputs that are high, and so never exceeds 2.
- R10: An issued opcode appears unchanged on the payload output of the pipe it is steered to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, sampled only by the embedded checks |
| rst_n | input | 1 | Active-low reset; turns the embedded checks off while low |
| s0_vld | input | 1 | Oldest buffer entry is present |
| s0_op | input | OPW | Opcode of the oldest entry |
| s1_vld | input | 1 | Second-oldest buffer entry is present |
| s1_op | input | OPW | Opcode of the second-oldest entry |
| alu_rdy | input | 1 | Arithmetic pipe can accept an entry this cycle |
| aux_rdy | input | 1 | General pipe can accept an entry this cycle |
| alu_vld | output | 1 | An entry issues to the arithmetic pipe |
| alu_op | output | OPW | Opcode issued to the arithmetic pipe |
| aux_vld | output | 1 | An entry issues to the general pipe |
| aux_op | output | OPW | Opcode issued to the general pipe |
| pop_cnt | output | 2 | Number of buffer entries consumed this cycle |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- each pipe receives only its own class;
- no pipe receives an entry while its ready input is low;
- the pop count agrees with the issue valids;
- a double pop occurs only for a valid mixed-class pair;
- an empty input never pops.

Other behaviour can only be shown by the bench's scenarios, because it depends on comparing against which entry should have gone out:
- program order under stalls;
- splitting of same-class pairs;
- a lone entry in slot 1;
- payload integrity.

The bench covers these with a behavioural queue model over a long random stream of opcodes with random pipe readiness.

// File: rtl/pair_steer.sv
module pair_steer #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] ARITH_MASK  = {2'b11, {(OPW-2){1'b0}}},
  parameter logic [OPW-1:0] ARITH_MATCH = {2'b01, {(OPW-2){1'b0}}}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s0_vld,
  input  logic [OPW-1:0] s0_op,
  input  logic           s1_vld,
  input  logic [OPW-1:0] s1_op,
  input  logic           alu_rdy,
  input  logic           aux_rdy,
  output logic           alu_vld,
  output logic [OPW-1:0] alu_op,
  output logic           aux_vld,
  output logic [OPW-1:0] aux_op,
  output logic [1:0]     pop_cnt
);

  function automatic logic is_alu(input logic [OPW-1:0] op);
    return (op & ARITH_MASK) == ARITH_MATCH;
  endfunction

  logic           old_vld, yng_vld, old_alu, yng_alu, old_go, yng_go;
  logic [OPW-1:0] old_op;

  // slot 1 becomes the oldest entry when slot 0 is empty
  assign old_vld = s0_vld | s1_vld;
  assign yng_vld = s0_vld & s1_vld;
  assign old_op  = s0_vld ? s0_op : s1_op;
  assign old_alu = is_alu(old_op);
  assign yng_alu = is_alu(s1_op);

  assign old_go = old_vld & (old_alu ? alu_rdy : aux_rdy);
  assign yng_go = old_go & yng_vld & (old_alu ^ yng_alu) & (yng_alu ? alu_rdy : aux_rdy);

  assign alu_vld = (old_go & old_alu) | (yng_go & yng_alu);
  assign alu_op  = (old_go & old_alu) ? old_op : s1_op;
  assign aux_vld = (old_go & ~old_alu) | (yng_go & ~yng_alu);
  assign aux_op  = (old_go & ~old_alu) ? old_op : s1_op;
  assign pop_cnt = {1'b0, old_go} + {1'b0, yng_go};

  p_alu_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alu_vld |-> is_alu(alu_op));
  p_aux_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aux_vld |-> !is_alu(aux_op));
  p_double_mixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cnt == 2'd2) |-> (s0_vld && s1_vld && (is_alu(s0_op) != is_alu(s1_op))));
  p_alu_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_vld |-> alu_rdy);
  p_aux_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_vld |-> aux_rdy);
  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s0_vld || s1_vld) |-> (pop_cnt == 2'd0 && !alu_vld && !aux_vld));
  p_pop_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_cnt == ({1'b0, alu_vld} + {1'b0, aux_vld}));

endmodule

// File: tb/sim_pair_steer.sv
module sim_pair_steer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0_vld = 1'b0, s1_vld = 1'b0, alu_rdy = 1'b0, aux_rdy = 1'b0;
  logic [7:0] s0_op = '0, s1_op = '0;
  logic       alu_vld, aux_vld;
  logic [7:0] alu_op, aux_op;
  logic [1:0] pop_cnt;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pair_steer u0 (
    .clk(clk), .rst_n(rst_n),
    .s0_vld(s0_vld), .s0_op(s0_op), .s1_vld(s1_vld), .s1_op(s1_op),
    .alu_rdy(alu_rdy), .aux_rdy(aux_rdy),
    .alu_vld(alu_vld), .alu_op(alu_op), .aux_vld(aux_vld), .aux_op(aux_op),
    .pop_cnt(pop_cnt)
  );

  // R1: arithmetic class iff bits [7:6] == 2'b01
  function automatic bit arith(input logic [7:0] op);
    return op[7:6] == 2'b01;
  endfunction

  function automatic logic [7:0] gen_op();
    logic [1:0] top;
    if ($urandom % 2 == 0) top = 2'b01;
    else case ($urandom % 3)
      0: top = 2'b00;
      1: top = 2'b10;
      default: top = 2'b11;
    endcase
    return {top, 6'($urandom)};
  endfunction

  logic       m_av, m_xv;
  logic [7:0] m_ao, m_xo;
  int         m_pop;

  // behavioural model: walk the valid entries oldest first, stop at first blocked one
  task automatic model(input logic v0, input logic [7:0] o0, input logic v1,
                       input logic [7:0] o1, input logic ar, input logic xr);
    logic [7:0] lst[$];
    m_av = 0; m_xv = 0; m_ao = '0; m_xo = '0; m_pop = 0;
    if (v0) lst.push_back(o0);
    if (v1) lst.push_back(o1);
    foreach (lst[k]) begin
      if (arith(lst[k])) begin
        if (m_av || !ar) break;
        m_av = 1; m_ao = lst[k];
      end else begin
        if (m_xv || !xr) break;
        m_xv = 1; m_xo = lst[k];
      end
      m_pop++;
    end
  endtask

  task automatic apply(input string tag, input logic v0, input logic [7:0] o0,
                       input logic v1, input logic [7:0] o1, input logic ar,
                       input logic xr, input int hand_pop);
    bit bad;
    @(negedge clk);
    s0_vld = v0; s0_op = o0; s1_vld = v1; s1_op = o1; alu_rdy = ar; aux_rdy = xr;
    #(CLK_P/4);
    model(v0, o0, v1, o1, ar, xr);
    if (hand_pop >= 0 && hand_pop != m_pop) begin
      $display("bench model disagrees with hand value in %s", tag);
      fails++;
    end
    bad = (alu_vld !== m_av) || (aux_vld !== m_xv) || (pop_cnt !== 2'(m_pop)) ||
          (m_av && alu_op !== m_ao) || (m_xv && aux_op !== m_xo);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: got av=%0b ao=%h xv=%0b xo=%h pop=%0d exp av=%0b ao=%h xv=%0b xo=%h pop=%0d",
               tag, alu_vld, alu_op, aux_vld, aux_op, pop_cnt, m_av, m_ao, m_xv, m_xo, m_pop);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    // R8 reset state: empty inputs pop nothing
    apply("R8 reset", 0, 8'h00, 0, 8'h00, 1, 1, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    apply("R8 empty", 0, 8'h55, 0, 8'h12, 1, 1, 0);
    apply("R4 R10 mixed alu-first", 1, 8'h4A, 1, 8'h8C, 1, 1, 2);
    apply("R4 R10 mixed aux-first", 1, 8'hC3, 1, 8'h7F, 1, 1, 2);
    apply("R5 R2 two arith", 1, 8'h41, 1, 8'h42, 1, 1, 1);
    apply("R5 R3 two general", 1, 8'h05, 1, 8'hB6, 1, 1, 1);
    apply("R6 older alu busy", 1, 8'h50, 1, 8'h20, 0, 1, 0);
    apply("R6 older aux busy", 1, 8'h9E, 1, 8'h61, 1, 0, 0);
    apply("R7 younger aux busy", 1, 8'h44, 1, 8'hE1, 1, 0, 1);
    apply("R7 younger alu busy", 1, 8'h11, 1, 8'h7E, 0, 1, 1);
    apply("R8 lone slot0", 1, 8'h6D, 0, 8'h01, 1, 1, 1);
    apply("R8 lone slot1", 0, 8'h3C, 1, 8'hA7, 1, 1, 1);
    apply("R8 lone slot1 alu", 0, 8'h88, 1, 8'h40, 1, 0, 1);
    apply("R1 boundary 3F general", 1, 8'h3F, 1, 8'h80, 1, 1, 1);
    apply("R1 boundary 7F arith", 1, 8'h7F, 1, 8'hBF, 1, 1, 2);

    // random stream; queue pops only what the model issues, so order is preserved
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom % 8 != 0)
        while (q.size() < 2) q.push_back(gen_op());
      apply("RAND R2 R3 R4 R5 R6 R7 R9 R10",
            q.size() > 0, q.size() > 0 ? q[0] : 8'h00,
            q.size() > 1, q.size() > 1 ? q[1] : 8'h00,
            ($urandom % 4) != 0, ($urandom % 4) != 0, -1);
      for (int k = 0; k < m_pop; k++) void'(q.pop_front());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule